// File: doc/BRIEF.md
# USB Device Transmit Endpoint Stager

This block is the transmit side of a USB device controller with five IN endpoints. Each endpoint owns a 64-byte packet FIFO and a byte-count register that the CPU fills through a small byte-wide register port. After loading a packet, the CPU arms the endpoint by setting its ready flag. When the token decoder signals an IN token for an armed endpoint, the block moves the packet into one shared staging buffer, one byte per cycle. The staging buffer then feeds the line-side serializer through a valid/ready byte stream.

When the move finishes, the endpoint's ready flag drops and its transmit status bit rises. That bit means the FIFO is empty and may be refilled. It does not mean the host has received the data. While the staging buffer drains, the CPU can already load the next packet. A new move never starts while the staging buffer still holds bytes that have not been drained. For that reason a fast CPU cannot corrupt a packet in flight.

A raw status register holds the five endpoint bits and a start-of-frame bit. A mask register selects which raw bits reach the masked-status register and the single interrupt line. A write-one-to-clear register clears raw bits. A CPU write to a FIFO whose packet is still armed is dropped and is recorded in a sticky overrun register.

Top module: `usb_tx_stager`

## Requirements
- R1: There are five endpoints, 0 to 4. Each has its own FIFO, and its transmit status bit is raw-status bit e (address 0x00). The start-of-frame bit is raw bit 5.
- R2: Register map:
  - Writes to 0x10+e append bytes to FIFO e, starting at index 0.
  - Writes to 0x08+e set the byte count of endpoint e. Values above 64 are stored as 64. Reads of 0x08+e return the count.
  - Writing a 1 to bit e of 0x04 arms endpoint e. Reading 0x04 returns the ready flags.
  - Read data appears on the cycle after the read strobe.
- R3: An IN token (tok_valid with tok_ep) starts a move only if that endpoint is armed and the staging buffer is idle. A token for an unarmed endpoint, or for a number of 5 or more, produces no line traffic and no status change.
- R4: A token that arrives while the staging buffer still holds undrained bytes is ignored: the endpoint stays armed and its status bit stays clear. The packet being drained goes out intact.
- R5: When a move completes, the endpoint's ready flag clears and its raw status bit sets.
- R6: The staging buffer presents the packet bytes in FIFO order on line_valid/line_data and advances only when line_ready is high. It pulses line_done for one cycle after the last byte. A zero-length packet produces a line_done pulse and no bytes.
- R7: The CPU may load a new packet into an endpoint FIFO while that endpoint's previous packet is still draining, without changing the bytes being drained.
- R8: Masked status (0x02) is raw AND mask (mask at 0x01). irq is high exactly when masked status is nonzero, in the same cycle.
- R9: Writing a pattern to 0x03 clears the raw bits that are 1 in the pattern. A set event in the same cycle wins over the clear.
- R10: An accepted byte write to FIFO e clears raw status bit e.
- R11: A sof_pulse sets raw bit 5.
- R12: While endpoint e is armed, writes to its FIFO or to its count are ignored. A FIFO write in that state sets bit e of the sticky overrun register (0x05). Writing 1s to 0x05 clears the corresponding overrun bits.
- R13: After reset, every register reads 0, irq is 0 and line_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 6 | Register address |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, one cycle after cpu_rd |
| tok_valid | input | 1 | IN token received |
| tok_ep | input | 3 | Endpoint number of the IN token |
| sof_pulse | input | 1 | Start-of-frame event |
| line_valid | output | 1 | Staging byte available |
| line_data | output | 8 | Staging byte |
| line_ready | input | 1 | Line side takes the byte |
| line_done | output | 1 | One-cycle pulse after the last byte of a packet |
| irq | output | 1 | Interrupt, OR of masked status |

## Verification
Two status functions can act on the same raw bit in the same cycle: a set event (start of frame, or the end of a move) and a CPU write to the clear register. The bench raises sof_pulse in exactly the cycle of a clear write that targets bit 5. It then expects the bit to read back as set and irq to follow the mask. A second collision is staged between an IN token and a staging buffer that is held full by a stalled line. The bench judges that case by the ready flags, the status bits and the drained bytes.

// File: rtl/ustx_pkg.sv
package ustx_pkg;
  localparam int ADDR_W = 6;
  localparam int REG_W  = 8;

  localparam logic [ADDR_W-1:0] A_RAW        = 6'h00;
  localparam logic [ADDR_W-1:0] A_MASK       = 6'h01;
  localparam logic [ADDR_W-1:0] A_MASKED     = 6'h02;
  localparam logic [ADDR_W-1:0] A_CLEAR      = 6'h03;
  localparam logic [ADDR_W-1:0] A_READY      = 6'h04;
  localparam logic [ADDR_W-1:0] A_OVR        = 6'h05;
  localparam logic [ADDR_W-1:0] A_COUNT_BASE = 6'h08;
  localparam logic [ADDR_W-1:0] A_DATA_BASE  = 6'h10;

  typedef enum logic [0:0] {MV_IDLE, MV_COPY} mv_state_t;
endpackage

// File: rtl/ustx_fifo_ram.sv
module ustx_fifo_ram #(
  parameter int NUM_EP = 5,
  parameter int DEPTH  = 64,
  parameter int DW     = 8,
  localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int IW    = $clog2(DEPTH),
  localparam int AW    = EPW + IW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [0:(1<<AW)-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ustx_stage_buf.sv
module ustx_stage_buf #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_we,
  input  logic [IW-1:0] ld_idx,
  input  logic [DW-1:0] ld_data,
  input  logic          start,
  input  logic [CW-1:0] start_len,
  output logic          busy,
  output logic          line_valid,
  output logic [DW-1:0] line_data,
  input  logic          line_ready,
  output logic          line_done
);
  logic [DW-1:0] mem [0:DEPTH-1];
  logic          active_q;
  logic          done_q;
  logic [CW-1:0] idx_q;
  logic [CW-1:0] len_q;

  always_ff @(posedge clk) begin
    if (ld_we) mem[ld_idx] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      idx_q    <= '0;
      len_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        len_q <= start_len;
        idx_q <= '0;
        if (start_len == '0) done_q   <= 1'b1;
        else                 active_q <= 1'b1;
      end else if (active_q && line_ready) begin
        if (idx_q == len_q - CW'(1)) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          idx_q <= idx_q + CW'(1);
        end
      end
    end
  end

  assign busy       = active_q;
  assign line_valid = active_q;
  assign line_data  = mem[idx_q[IW-1:0]];
  assign line_done  = done_q;

  AST_NO_STAGE_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
    (ld_we || start) |-> !active_q); // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    line_done |-> !line_valid); // R6
endmodule

// File: rtl/ustx_mover.sv
module ustx_mover
  import ustx_pkg::*;
#(
  parameter int NUM_EP = 5,
  parameter int DEPTH  = 64,
  parameter int DW     = 8,
  localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int AW    = EPW + IW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tok_valid,
  input  logic [EPW-1:0]     tok_ep,
  input  logic [NUM_EP-1:0]  ready_flags,
  input  logic [NUM_EP*CW-1:0] cnt_flat,
  input  logic               stage_busy,
  output logic [AW-1:0]      ram_raddr,
  input  logic [DW-1:0]      ram_rdata,
  output logic               ld_we,
  output logic [IW-1:0]      ld_idx,
  output logic [DW-1:0]      ld_data,
  output logic               fin_start,
  output logic [CW-1:0]      fin_len,
  output logic [NUM_EP-1:0]  done_vec
);
  localparam logic [EPW:0] EP_LIM = (EPW+1)'(NUM_EP);

  mv_state_t     state_q;
  logic [EPW-1:0] ep_q;
  logic [CW-1:0] len_q;
  logic [CW-1:0] rd_q;
  logic [CW-1:0] wi_q;
  logic          iss_q;
  logic          ep_ok;
  logic          accept;
  logic          fin;

  assign ep_ok  = ({1'b0, tok_ep} < EP_LIM);
  assign accept = tok_valid && (state_q == MV_IDLE) && !stage_busy && ep_ok && ready_flags[tok_ep];
  assign fin    = (state_q == MV_COPY) && (wi_q == len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= MV_IDLE;
      ep_q    <= '0;
      len_q   <= '0;
      rd_q    <= '0;
      wi_q    <= '0;
      iss_q   <= 1'b0;
    end else begin
      case (state_q)
        MV_IDLE: begin
          if (accept) begin
            state_q <= MV_COPY;
            ep_q    <= tok_ep;
            len_q   <= cnt_flat[int'(tok_ep)*CW +: CW];
            rd_q    <= '0;
            wi_q    <= '0;
            iss_q   <= 1'b0;
          end
        end
        default: begin
          if (fin) begin
            state_q <= MV_IDLE;
            iss_q   <= 1'b0;
          end else begin
            if (rd_q < len_q) begin
              rd_q  <= rd_q + CW'(1);
              iss_q <= 1'b1;
            end else begin
              iss_q <= 1'b0;
            end
            if (iss_q) wi_q <= wi_q + CW'(1);
          end
        end
      endcase
    end
  end

  assign ram_raddr = {ep_q, rd_q[IW-1:0]};
  assign ld_we     = (state_q == MV_COPY) && iss_q;
  assign ld_idx    = wi_q[IW-1:0];
  assign ld_data   = ram_rdata;
  assign fin_start = fin;
  assign fin_len   = len_q;

  always_comb begin
    done_vec = '0;
    if (fin) done_vec[ep_q] = 1'b1;
  end

  AST_COPY_IDLE_STAGE: assert property (@(posedge clk) disable iff (rst)
    (state_q == MV_COPY) |-> !stage_busy); // R4
endmodule

// File: rtl/ustx_irq_regs.sv
module ustx_irq_regs #(
  parameter int NB = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set_bits,
  input  logic [NB-1:0] clr_bits,
  input  logic          mask_we,
  input  logic [NB-1:0] mask_wdata,
  output logic [NB-1:0] raw,
  output logic [NB-1:0] mask,
  output logic [NB-1:0] masked,
  output logic          irq
);
  logic [NB-1:0] raw_q, raw_d;
  logic [NB-1:0] mask_q, mask_d;
  logic          irq_q;

  assign raw_d  = (raw_q & ~clr_bits) | set_bits;
  assign mask_d = mask_we ? mask_wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
      irq_q  <= |(raw_d & mask_d);
    end
  end

  assign raw    = raw_q;
  assign mask   = mask_q;
  assign masked = raw_q & mask_q;
  assign irq    = irq_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set_bits) |=> ((raw_q & $past(set_bits)) == $past(set_bits))); // R9
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    irq_q == (masked != '0)); // R8
endmodule

// File: rtl/usb_tx_stager.sv
module usb_tx_stager
  import ustx_pkg::*;
#(
  parameter int NUM_EP = 5,
  parameter int DEPTH  = 64,
  parameter int DW     = 8,
  localparam int EPW   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int IW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int AW    = EPW + IW,
  localparam int NB    = NUM_EP + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [REG_W-1:0]  cpu_wdata,
  output logic [REG_W-1:0]  cpu_rdata,
  input  logic              tok_valid,
  input  logic [EPW-1:0]    tok_ep,
  input  logic              sof_pulse,
  output logic              line_valid,
  output logic [DW-1:0]     line_data,
  input  logic              line_ready,
  output logic              line_done,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] DATA_END  = A_DATA_BASE + ADDR_W'(NUM_EP);
  localparam logic [ADDR_W-1:0] COUNT_END = A_COUNT_BASE + ADDR_W'(NUM_EP);

  logic [NUM_EP-1:0]    ready_q, ovr_q;
  logic [CW-1:0]        cnt_q  [NUM_EP];
  logic [IW-1:0]        wptr_q [NUM_EP];
  logic [NUM_EP*CW-1:0] cnt_flat;
  logic [REG_W-1:0]     rdata_q;

  logic [EPW-1:0] a_ep;
  logic           in_data, in_cnt;
  logic           data_ok, data_bad, cnt_wr;
  logic [CW-1:0]  cnt_val;
  logic [NUM_EP-1:0] ready_set, ovr_set, ovr_clr, done_vec;
  logic [NB-1:0]  set_bits, clr_bits, raw, mask, masked;

  logic [AW-1:0]  ram_raddr;
  logic [DW-1:0]  ram_rdata;
  logic           ld_we, fin_start, stage_busy;
  logic [IW-1:0]  ld_idx;
  logic [DW-1:0]  ld_data;
  logic [CW-1:0]  fin_len;

  assign a_ep     = cpu_addr[EPW-1:0];
  assign in_data  = (cpu_addr >= A_DATA_BASE) && (cpu_addr < DATA_END);
  assign in_cnt   = (cpu_addr >= A_COUNT_BASE) && (cpu_addr < COUNT_END);
  assign data_ok  = cpu_wr && in_data && !ready_q[a_ep];
  assign data_bad = cpu_wr && in_data && ready_q[a_ep];
  assign cnt_wr   = cpu_wr && in_cnt && !ready_q[a_ep];
  assign cnt_val  = (cpu_wdata > REG_W'(DEPTH)) ? CW'(DEPTH) : CW'(cpu_wdata);

  always_comb begin
    ready_set = '0;
    ovr_set   = '0;
    ovr_clr   = '0;
    clr_bits  = '0;
    if (cpu_wr && cpu_addr == A_READY) ready_set = cpu_wdata[NUM_EP-1:0] & ~ready_q;
    if (cpu_wr && cpu_addr == A_OVR)   ovr_clr   = cpu_wdata[NUM_EP-1:0];
    if (cpu_wr && cpu_addr == A_CLEAR) clr_bits  = cpu_wdata[NB-1:0];
    if (data_bad) ovr_set[a_ep]  = 1'b1;
    if (data_ok)  clr_bits[a_ep] = 1'b1;
  end

  assign set_bits = {sof_pulse, done_vec};

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= '0;
      ovr_q   <= '0;
      for (int e = 0; e < NUM_EP; e++) begin
        cnt_q[e]  <= '0;
        wptr_q[e] <= '0;
      end
    end else begin
      ready_q <= (ready_q & ~done_vec) | ready_set;
      ovr_q   <= (ovr_q & ~ovr_clr) | ovr_set;
      for (int e = 0; e < NUM_EP; e++) begin
        if (done_vec[e])                            wptr_q[e] <= '0;
        else if (data_ok && a_ep == EPW'(e))        wptr_q[e] <= wptr_q[e] + IW'(1);
        if (cnt_wr && a_ep == EPW'(e))              cnt_q[e]  <= cnt_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (cpu_rd) begin
      if      (cpu_addr == A_RAW)    rdata_q <= REG_W'(raw);
      else if (cpu_addr == A_MASK)   rdata_q <= REG_W'(mask);
      else if (cpu_addr == A_MASKED) rdata_q <= REG_W'(masked);
      else if (cpu_addr == A_READY)  rdata_q <= REG_W'(ready_q);
      else if (cpu_addr == A_OVR)    rdata_q <= REG_W'(ovr_q);
      else if (in_cnt)               rdata_q <= REG_W'(cnt_q[a_ep]);
      else                           rdata_q <= '0;
    end
  end
  assign cpu_rdata = rdata_q;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_cnt
    assign cnt_flat[g*CW +: CW] = cnt_q[g];
  end

  ustx_fifo_ram #(.NUM_EP(NUM_EP), .DEPTH(DEPTH), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (data_ok),
    .waddr ({a_ep, wptr_q[a_ep]}),
    .wdata (cpu_wdata[DW-1:0]),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  ustx_mover #(.NUM_EP(NUM_EP), .DEPTH(DEPTH), .DW(DW)) u_mover (
    .clk         (clk),
    .rst         (rst),
    .tok_valid   (tok_valid),
    .tok_ep      (tok_ep),
    .ready_flags (ready_q),
    .cnt_flat    (cnt_flat),
    .stage_busy  (stage_busy),
    .ram_raddr   (ram_raddr),
    .ram_rdata   (ram_rdata),
    .ld_we       (ld_we),
    .ld_idx      (ld_idx),
    .ld_data     (ld_data),
    .fin_start   (fin_start),
    .fin_len     (fin_len),
    .done_vec    (done_vec)
  );

  ustx_stage_buf #(.DEPTH(DEPTH), .DW(DW)) u_stage (
    .clk        (clk),
    .rst        (rst),
    .ld_we      (ld_we),
    .ld_idx     (ld_idx),
    .ld_data    (ld_data),
    .start      (fin_start),
    .start_len  (fin_len),
    .busy       (stage_busy),
    .line_valid (line_valid),
    .line_data  (line_data),
    .line_ready (line_ready),
    .line_done  (line_done)
  );

  ustx_irq_regs #(.NB(NB)) u_irq (
    .clk        (clk),
    .rst        (rst),
    .set_bits   (set_bits),
    .clr_bits   (clr_bits),
    .mask_we    (cpu_wr && cpu_addr == A_MASK),
    .mask_wdata (cpu_wdata[NB-1:0]),
    .raw        (raw),
    .mask       (mask),
    .masked     (masked),
    .irq        (irq)
  );

  AST_DONE_WAS_READY: assert property (@(posedge clk) disable iff (rst)
    (|done_vec) |-> ((done_vec & ready_q) == done_vec)); // R5
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (|done_vec) |=> ((ready_q & $past(done_vec)) == '0)); // R5
  AST_ARMED_FIFO_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && in_data && ready_q[a_ep]) |=> ovr_q[$past(a_ep)]); // R12
endmodule

// File: tb/usb_tx_stager_bench.sv
`timescale 1ns/1ps
module usb_tx_stager_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       cpu_wr, cpu_rd;
  logic [5:0] cpu_addr;
  logic [7:0] cpu_wdata;
  logic [7:0] cpu_rdata;
  logic       tok_valid;
  logic [2:0] tok_ep;
  logic       sof_pulse;
  logic       line_valid;
  logic [7:0] line_data;
  logic       line_ready;
  logic       line_done;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  int cap_n = 0;
  int done_cnt = 0;
  int cyc = 0;
  bit hold_line = 0;
  bit stall_en = 0;
  logic [7:0] cap [0:127];

  usb_tx_stager u_usb_tx_stager (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tok_valid(tok_valid), .tok_ep(tok_ep),
    .sof_pulse(sof_pulse), .line_valid(line_valid), .line_data(line_data),
    .line_ready(line_ready), .line_done(line_done), .irq(irq)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    line_ready = !hold_line && !(stall_en && (cyc % 3 == 1));
    if (line_valid && line_ready) begin
      if (cap_n < 128) cap[cap_n] = line_data;
      cap_n++;
    end
    if (line_done) done_cnt++;
  end

  function automatic logic [7:0] pat(int ep, int i);
    return 8'(ep * 37 + i * 5 + 3);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output int v);
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk);
    cpu_rd = 1'b0;
    v = int'(cpu_rdata);
  endtask

  task automatic token(input int ep);
    @(negedge clk);
    tok_valid = 1'b1; tok_ep = 3'(ep);
    @(negedge clk);
    tok_valid = 1'b0;
  endtask

  task automatic load(input int ep, input int n, input int base);
    wr(6'(8 + ep), 8'(n));
    for (int i = 0; i < n; i++) wr(6'(16 + ep), pat(ep, base + i));
  endtask

  task automatic wait_done(input int prev);
    for (int i = 0; i < 3000; i++) begin
      if (done_cnt > prev) break;
      @(negedge clk);
    end
  endtask

  task automatic cmp_packet(input string tag, input int ep, input int n);
    int bad;
    bad = 0;
    chk({tag, " byte count"}, cap_n, n);
    for (int i = 0; i < n && i < 128; i++) if (cap[i] !== pat(ep, i)) bad++;
    chk({tag, " byte mismatches"}, bad, 0);
  endtask

  task automatic t_reset;
    int v;
    rd(6'h00, v); chk("R13 raw after reset", v, 0);
    rd(6'h01, v); chk("R13 mask after reset", v, 0);
    rd(6'h04, v); chk("R13 ready after reset", v, 0);
    rd(6'h05, v); chk("R13 overrun after reset", v, 0);
    chk("R13 irq after reset", int'(irq), 0);
    chk("R13 line_valid after reset", int'(line_valid), 0);
  endtask

  task automatic t_basic;
    int v, d0;
    load(1, 8, 0);
    wr(6'h04, 8'h02);
    rd(6'h04, v); chk("R2 ready flag armed", v, 2);
    rd(6'h09, v); chk("R2 count readback", v, 8);
    cap_n = 0; d0 = done_cnt;
    token(1);
    wait_done(d0);
    cmp_packet("R6 basic ep1", 1, 8);
    rd(6'h00, v); chk("R5 R1 raw bit1 only", v, 2);
    rd(6'h04, v); chk("R5 ready cleared", v, 0);
    chk("R8 irq masked off", int'(irq), 0);
    wr(6'h01, 8'h02);
    chk("R8 irq after mask", int'(irq), 1);
    rd(6'h02, v); chk("R8 masked status", v, 2);
    wr(6'h03, 8'h02);
    rd(6'h00, v); chk("R9 raw after clear", v, 0);
    chk("R8 irq after clear", int'(irq), 0);
    wr(6'h01, 8'h00);
  endtask

  task automatic t_unarmed;
    int v, d0;
    d0 = done_cnt; cap_n = 0;
    token(2);
    token(7);
    repeat (20) @(negedge clk);
    chk("R3 no bytes for unarmed tokens", cap_n, 0);
    chk("R3 no done for unarmed tokens", done_cnt, d0);
    rd(6'h00, v); chk("R3 raw unchanged", v, 0);
  endtask

  task automatic t_busy;
    int v, d0;
    load(0, 64, 0);
    load(3, 5, 0);
    wr(6'h04, 8'h09);
    hold_line = 1; cap_n = 0; d0 = done_cnt;
    token(0);
    repeat (90) @(negedge clk);
    rd(6'h00, v); chk("R5 raw bit0 after move", v, 1);
    chk("R6 line held valid", int'(line_valid), 1);
    token(3);
    repeat (10) @(negedge clk);
    rd(6'h04, v); chk("R4 ep3 still armed", v, 8);
    rd(6'h00, v); chk("R4 ep3 status still clear", v & 8, 0);
    for (int i = 0; i < 3; i++) wr(6'h10, pat(9, i));
    rd(6'h00, v); chk("R10 refill clears bit0", v, 0);
    stall_en = 1; hold_line = 0;
    wait_done(d0);
    cmp_packet("R4 R7 drained ep0 intact", 0, 64);
    stall_en = 0;
    cap_n = 0; d0 = done_cnt;
    token(3);
    wait_done(d0);
    cmp_packet("R3 ep3 after stage idle", 3, 5);
    rd(6'h00, v); chk("R1 raw bit3 only", v, 8);
    wr(6'h03, 8'h3F);
  endtask

  task automatic t_zlp;
    int v, d0;
    wr(6'h0C, 8'h00);
    wr(6'h04, 8'h10);
    cap_n = 0; d0 = done_cnt;
    token(4);
    wait_done(d0);
    chk("R6 zero-length done pulse", done_cnt, d0 + 1);
    chk("R6 zero-length no bytes", cap_n, 0);
    rd(6'h00, v); chk("R1 R5 raw bit4", v, 16);
    wr(6'h03, 8'h3F);
  endtask

  task automatic t_overrun;
    int v, d0;
    load(2, 2, 0);
    wr(6'h04, 8'h04);
    wr(6'h12, 8'hAA);
    rd(6'h05, v); chk("R12 overrun bit2 set", v, 4);
    wr(6'h0A, 8'h09);
    rd(6'h0A, v); chk("R12 count write ignored", v, 2);
    cap_n = 0; d0 = done_cnt;
    token(2);
    wait_done(d0);
    cmp_packet("R12 ep2 data untouched", 2, 2);
    wr(6'h05, 8'h04);
    rd(6'h05, v); chk("R12 overrun cleared", v, 0);
    wr(6'h03, 8'h3F);
  endtask

  task automatic t_count_sat;
    int v;
    wr(6'h09, 8'd100);
    rd(6'h09, v); chk("R2 count saturates", v, 64);
    wr(6'h09, 8'd63);
    rd(6'h09, v); chk("R2 count in range", v, 63);
  endtask

  task automatic t_sof;
    int v;
    @(negedge clk);
    sof_pulse = 1'b1; cpu_wr = 1'b1; cpu_addr = 6'h03; cpu_wdata = 8'h20;
    @(negedge clk);
    sof_pulse = 1'b0; cpu_wr = 1'b0;
    rd(6'h00, v); chk("R9 R11 set wins over same-cycle clear", v, 32);
    wr(6'h01, 8'h20);
    chk("R8 irq from sof", int'(irq), 1);
    wr(6'h03, 8'h20);
    rd(6'h00, v); chk("R9 sof cleared", v, 0);
    chk("R8 irq low after clear", int'(irq), 0);
    wr(6'h01, 8'h00);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    rst = 1'b1; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    tok_valid = 1'b0; tok_ep = '0; sof_pulse = 1'b0; line_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_unarmed();
    t_busy();
    t_zlp();
    t_overrun();
    t_count_sat();
    t_sof();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule